// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This unit is the buffering and signalling layer between a processor's register bus and a byte-wide serial shift engine. Software writes 32-bit words into a transmit FIFO, and the serial engine drains it a byte at a time. The engine pushes received bytes into a receive FIFO, and software reads them back either as a whole word or one byte at a time. Both FIFOs hold `DEPTH` bytes, 32 by default.

A single status word shows the live occupancy of both FIFOs, level flags and two sticky error flags. Software clears the sticky flags by writing ones to them. A mask word selects which status bits drive the one interrupt line. A configuration word holds two programmable thresholds. Each threshold raises a status bit when its FIFO crosses the level that is set.

Register access uses strobes. A read returns data in the same cycle as its strobe. A read of a receive register removes the bytes it returns at the clock edge that ends the strobe.

Register select codes on `reg_addr`: 0 configuration, 1 status (event), 2 mask, 3 transmit data, 4 receive word, 5 receive byte. Codes 6 and 7 read as zero, and writes to them have no effect.

Top module: `spi_fifo_evt_unit`

## Requirements
- R1: After reset the configuration word reads 0x0000_0403 (transmit threshold 4 in bits 13:8, receive threshold 3 in bits 5:0), the mask reads 0, the status reads 0x0000_0101, `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: A write to transmit data with at least four free bytes appends the four bytes of the word, bits 31:24 first. The serial side then receives them in that order through `tx_valid`/`tx_ready`. Status bits 21:16 give the live transmit byte count.
- R3: A write to transmit data with fewer than four free bytes stores nothing and sets sticky status bit 3 (transmit overflow).
- R4: A read of the receive word with at least four bytes stored returns the four oldest bytes, the oldest in bits 31:24, and removes them. Status bits 29:24 give the live receive byte count.
- R5: A read of the receive byte with at least one byte stored returns the oldest byte in bits 7:0 with the upper bits zero, and removes it.
- R6: A receive read that asks for more bytes than are stored returns zero, removes nothing and sets sticky status bit 2 (receive underflow).
- R7: Status bit 9 is high while the receive FIFO holds any byte. Status bit 8 is high while the transmit FIFO is below `DEPTH` bytes. These bits and both count fields follow the FIFOs every cycle, and writes to the status word do not change them.
- R8: Writing a one to status bit 3 or bit 2 clears that sticky bit. Writing a zero leaves it set. A new error in the same cycle as the clear wins.
- R9: A configuration write sets the transmit threshold from bits 13:8 and the receive threshold from bits 5:0. Status bit 1 is high while the receive count is at or above the receive threshold. Status bit 0 is high while the transmit count is at or below the transmit threshold.
- R10: Only mask bits 9, 8, 3, 2, 1 and 0 are stored, and all other mask bits read as zero. `irq` is the OR of the status bits ANDed with the stored mask, and it follows a mask or status change in the cycle after that change.
- R11: While the receive FIFO holds `DEPTH` bytes, `rx_ready` is low and a byte offered on `rx_valid` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | The transmit FIFO holds a byte |
| tx_ready | input | 1 | The serial engine takes `tx_byte` |
| rx_byte | input | 8 | Received byte from the serial engine |
| rx_valid | input | 1 | `rx_byte` is offered |
| rx_ready | output | 1 | The receive FIFO has space |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The assertions check on every cycle that the occupancy counts move by exactly four or one on accepted word and byte transfers. They also check that errors set the sticky bits, that sticky bits hold until cleared, that an empty byte read returns zero, and that a full receive FIFO stalls its input. Byte ordering across the FIFOs, the exact content of the status word, the effect of the thresholds and the interrupt gating all need a scoreboard model. The bench's scenarios show these: it fills the transmit FIFO to overflow and drains it, fills the receive FIFO to capacity, makes short reads, and moves thresholds and masks.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;

  // Register select codes
  typedef enum logic [2:0] {
    RA_CFG = 3'd0,
    RA_EVT = 3'd1,
    RA_MSK = 3'd2,
    RA_TXD = 3'd3,
    RA_RXW = 3'd4,
    RA_RXB = 3'd5
  } reg_addr_e;

  localparam int unsigned WORD_B = 4;   // bytes in one bus word
  localparam int unsigned CNT_W  = 6;   // width of status count fields
  localparam int unsigned THR_W  = 6;   // width of threshold fields

  // Status word layout
  localparam int unsigned EB_RX_NE  = 9;
  localparam int unsigned EB_TX_NF  = 8;
  localparam int unsigned EB_TX_OVF = 3;
  localparam int unsigned EB_RX_UDF = 2;
  localparam int unsigned EB_RX_THR = 1;
  localparam int unsigned EB_TX_THR = 0;
  localparam int unsigned RXCNT_LSB = 24;
  localparam int unsigned TXCNT_LSB = 16;

  // Configuration word layout
  localparam int unsigned TXTHR_LSB = 8;
  localparam int unsigned RXTHR_LSB = 0;

  localparam logic [31:0] MASK_IMPL = 32'h0000_030F;

endpackage

// File: rtl/spi_byte_fifo.sv
// Byte FIFO that pushes PUSH_W bytes at once and pops 0..POP_W bytes.
// DEPTH must be a power of two so the pointers wrap naturally.
module spi_byte_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned PUSH_W = 4,
  parameter int unsigned POP_W  = 1,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1),
  localparam int unsigned PCW = $clog2(POP_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push_i,
  input  logic [PUSH_W*8-1:0]   push_data_i,   // byte k at [8k +: 8], k = 0 first
  input  logic [PCW-1:0]        pop_n_i,
  output logic [POP_W*8-1:0]    peek_o,        // byte k at [8k +: 8], k = 0 oldest
  output logic [CW-1:0]         count_o
);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;

  // Per-entry write decode
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [AW-1:0] off;
    logic          we;
    logic [7:0]    wb;
    always_comb begin
      off = AW'(e) - wr_ptr_q;
      we  = push_i && (32'(off) < PUSH_W);
      wb  = '0;
      for (int k = 0; k < PUSH_W; k++) begin
        if (off == AW'(k)) wb = push_data_i[8*k +: 8];
      end
    end
    always_ff @(posedge clk) begin
      if (we) mem_q[e] <= wb;
    end
  end

  for (genvar k = 0; k < POP_W; k++) begin : g_peek
    assign peek_o[8*k +: 8] = mem_q[rd_ptr_q + AW'(k)];
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    count_d  = count_q - CW'(pop_n_i);
    rd_ptr_d = rd_ptr_q + AW'(pop_n_i);
    if (push_i) begin
      wr_ptr_d = wr_ptr_q + AW'(PUSH_W);
      count_d  = count_d + CW'(PUSH_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/spi_evt_regs.sv
// Configuration, mask and sticky event registers, status assembly,
// interrupt gating and read-data selection.
module spi_evt_regs
  import spi_fifo_evt_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned TX_THR_RST = 4,
  parameter int unsigned RX_THR_RST = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [CW-1:0] tx_cnt_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic          ovf_set_i,
  input  logic          udf_set_i,
  input  logic [31:0]   rx_rdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o
);

  logic [THR_W-1:0] tx_thr_q, tx_thr_d;
  logic [THR_W-1:0] rx_thr_q, rx_thr_d;
  logic [31:0]      mask_q, mask_d;
  logic             ovf_q, ovf_d;
  logic             udf_q, udf_d;
  logic [31:0]      evt;
  logic             wr_cfg, wr_evt, wr_msk;

  assign wr_cfg = wr_en_i && (addr_i == RA_CFG);
  assign wr_evt = wr_en_i && (addr_i == RA_EVT);
  assign wr_msk = wr_en_i && (addr_i == RA_MSK);

  // Next-state
  always_comb begin
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    mask_d   = mask_q;
    ovf_d    = ovf_q;
    udf_d    = udf_q;
    if (wr_cfg) begin
      tx_thr_d = wdata_i[TXTHR_LSB +: THR_W];
      rx_thr_d = wdata_i[RXTHR_LSB +: THR_W];
    end
    if (wr_msk) mask_d = wdata_i & MASK_IMPL;
    if (wr_evt && wdata_i[EB_TX_OVF]) ovf_d = 1'b0;
    if (wr_evt && wdata_i[EB_RX_UDF]) udf_d = 1'b0;
    if (ovf_set_i) ovf_d = 1'b1;
    if (udf_set_i) udf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= THR_W'(TX_THR_RST);
      rx_thr_q <= THR_W'(RX_THR_RST);
      mask_q   <= '0;
      ovf_q    <= 1'b0;
      udf_q    <= 1'b0;
    end else begin
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
      mask_q   <= mask_d;
      ovf_q    <= ovf_d;
      udf_q    <= udf_d;
    end
  end

  // Status word: live counts and levels, plus sticky errors
  always_comb begin
    evt = '0;
    evt[RXCNT_LSB +: CNT_W] = CNT_W'(rx_cnt_i);
    evt[TXCNT_LSB +: CNT_W] = CNT_W'(tx_cnt_i);
    evt[EB_RX_NE]  = (rx_cnt_i != '0);
    evt[EB_TX_NF]  = (32'(tx_cnt_i) < DEPTH);
    evt[EB_TX_OVF] = ovf_q;
    evt[EB_RX_UDF] = udf_q;
    evt[EB_RX_THR] = (32'(rx_cnt_i) >= 32'(rx_thr_q));
    evt[EB_TX_THR] = (32'(tx_cnt_i) <= 32'(tx_thr_q));
  end

  assign irq_o = |(evt & mask_q);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        RA_CFG:  rdata_o = 32'(tx_thr_q) << TXTHR_LSB | 32'(rx_thr_q) << RXTHR_LSB;
        RA_EVT:  rdata_o = evt;
        RA_MSK:  rdata_o = mask_q;
        RA_RXW,
        RA_RXB:  rdata_o = rx_rdata_i;
        default: rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_fifo_evt_unit.sv
module spi_fifo_evt_unit
  import spi_fifo_evt_pkg::*;
#(
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned TX_THR_RST = 4,
  parameter int unsigned RX_THR_RST = 3,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic        irq
);

  logic [CW-1:0]         tx_cnt, rx_cnt;
  logic                  tx_wr, tx_room, tx_push, tx_pop;
  logic [WORD_B*8-1:0]   tx_push_data;
  logic                  rx_push, rxw_rd, rxb_rd, rxw_ok, rxb_ok;
  logic [2:0]            rx_pop_n;
  logic [WORD_B*8-1:0]   rx_peek;
  logic [31:0]           rx_rdata;
  logic                  ovf_set, udf_set;

  // Transmit side: whole-word pushes, MSB first
  assign tx_wr   = reg_wr_en && (reg_addr == RA_TXD);
  assign tx_room = (32'(tx_cnt) + WORD_B) <= DEPTH;
  assign tx_push = tx_wr && tx_room;
  assign ovf_set = tx_wr && !tx_room;
  assign tx_valid = (tx_cnt != '0);
  assign tx_pop   = tx_valid && tx_ready;

  for (genvar k = 0; k < WORD_B; k++) begin : g_txb
    assign tx_push_data[8*k +: 8] = reg_wdata[32-8*k-1 -: 8];
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_W(1'b1 ? WORD_B : 1), .POP_W(1)) u_tx_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (tx_push),
    .push_data_i (tx_push_data),
    .pop_n_i     (tx_pop),
    .peek_o      (tx_byte),
    .count_o     (tx_cnt)
  );

  // Receive side: byte pushes, word or byte pops
  assign rx_ready = 32'(rx_cnt) < DEPTH;
  assign rx_push  = rx_valid && rx_ready;
  assign rxw_rd   = reg_rd_en && (reg_addr == RA_RXW);
  assign rxb_rd   = reg_rd_en && (reg_addr == RA_RXB);
  assign rxw_ok   = 32'(rx_cnt) >= WORD_B;
  assign rxb_ok   = (rx_cnt != '0);
  assign udf_set  = (rxw_rd && !rxw_ok) || (rxb_rd && !rxb_ok);

  always_comb begin
    rx_pop_n = '0;
    rx_rdata = '0;
    if (rxw_rd && rxw_ok) begin
      rx_pop_n = 3'(WORD_B);
      for (int k = 0; k < WORD_B; k++) rx_rdata[32-8*k-1 -: 8] = rx_peek[8*k +: 8];
    end else if (rxb_rd && rxb_ok) begin
      rx_pop_n = 3'd1;
      rx_rdata = {24'd0, rx_peek[7:0]};
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(WORD_B)) u_rx_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (rx_push),
    .push_data_i (rx_byte),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );

  spi_evt_regs #(.DEPTH(DEPTH), .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (reg_wr_en),
    .rd_en_i    (reg_rd_en),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .tx_cnt_i   (tx_cnt),
    .rx_cnt_i   (rx_cnt),
    .ovf_set_i  (ovf_set),
    .udf_set_i  (udf_set),
    .rx_rdata_i (rx_rdata),
    .rdata_o    (reg_rdata),
    .irq_o      (irq)
  );

endmodule

// File: rtl/spi_fifo_evt_unit_chk.sv
module spi_fifo_evt_unit_chk
  import spi_fifo_evt_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_en,
  input logic          reg_rd_en,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          ovf_q,
  input logic          udf_q
);

  logic txw, rxw, rxb, evw;
  assign txw = reg_wr_en && (reg_addr == RA_TXD);
  assign rxw = reg_rd_en && (reg_addr == RA_RXW);
  assign rxb = reg_rd_en && (reg_addr == RA_RXB);
  assign evw = reg_wr_en && (reg_addr == RA_EVT);

  AST_TX_PUSH_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    txw && (32'(tx_cnt) + 4 <= DEPTH) && !(tx_valid && tx_ready)
      |=> 32'(tx_cnt) == 32'($past(tx_cnt)) + 4); // R2

  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    txw && (32'(tx_cnt) + 4 > DEPTH) |=> ovf_q); // R3

  AST_RX_WORD_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rxw && (32'(rx_cnt) >= 4) && !(rx_valid && rx_ready)
      |=> 32'(rx_cnt) + 4 == 32'($past(rx_cnt))); // R4

  AST_RX_BYTE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rxb && (rx_cnt != '0) && !(rx_valid && rx_ready)
      |=> 32'(rx_cnt) + 1 == 32'($past(rx_cnt))); // R5

  AST_RX_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rxb && (rx_cnt == '0) |-> reg_rdata == 32'd0); // R6

  AST_RX_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rxw && 32'(rx_cnt) < 4) |=> udf_q); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q && !evw |=> udf_q); // R8

  AST_RX_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) == DEPTH |-> !rx_ready); // R11

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_cnt) <= DEPTH && 32'(rx_cnt) <= DEPTH); // R7

endmodule

bind spi_fifo_evt_unit spi_fifo_evt_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .ovf_q     (u_regs.ovf_q),
  .udf_q     (u_regs.udf_q)
);

// File: tb/spi_fifo_evt_unit_bench.sv
module spi_fifo_evt_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  tx_byte, rx_byte;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;

  int tests = 0;
  int fails = 0;

  // Scoreboard model
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic       m_ovf = 1'b0, m_udf = 1'b0;
  int         m_txthr = 4, m_rxthr = 3;
  logic [31:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_evt_unit u_spi_fifo_evt_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_evt();
    logic [31:0] e = '0;
    e[29:24] = 6'(rxq.size());
    e[21:16] = 6'(txq.size());
    e[9] = rxq.size() != 0;
    e[8] = txq.size() < DEPTH;
    e[3] = m_ovf;
    e[2] = m_udf;
    e[1] = rxq.size() >= m_rxthr;
    e[0] = txq.size() <= m_txthr;
    return e;
  endfunction

  // Transmit monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (txq.size() == 0) check("R2 unexpected tx byte", {24'd0, tx_byte}, 32'hFFFF_FFFF);
      else check("R2 tx byte order", {24'd0, tx_byte}, {24'd0, txq.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic tx_word(input logic [31:0] w);
    if (txq.size() + 4 <= DEPTH) begin
      for (int k = 3; k >= 0; k--) txq.push_back(w[8*k +: 8]);
    end else m_ovf = 1'b1;
    wr(3'd3, w);
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    #1 if (rxq.size() == DEPTH) check("R11 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    rx_valid = 1'b1; rx_byte = b;
    if (rxq.size() < DEPTH) rxq.push_back(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rx_word(input string req);
    logic [31:0] exp, d;
    if (rxq.size() >= 4) begin
      exp = {rxq[0], rxq[1], rxq[2], rxq[3]};
      repeat (4) void'(rxq.pop_front());
    end else begin
      exp = '0; m_udf = 1'b1;
    end
    rd(3'd4, d);
    check(req, d, exp);
  endtask

  task automatic rx_one(input string req);
    logic [31:0] exp, d;
    if (rxq.size() >= 1) exp = {24'd0, rxq.pop_front()};
    else begin exp = '0; m_udf = 1'b1; end
    rd(3'd5, d);
    check(req, d, exp);
  endtask

  task automatic chk_evt(input string req);
    logic [31:0] d;
    rd(3'd1, d);
    check(req, d, exp_evt());
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    #1 check(req, {31'd0, irq}, {31'd0, |(exp_evt() & m_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    tx_ready = 0; rx_valid = 0; rx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    rd(3'd0, d); check("R1 cfg reset", d, 32'h0000_0403);
    rd(3'd2, d); check("R1 mask reset", d, 32'd0);
    rd(3'd1, d); check("R1 evt reset", d, 32'h0000_0101);

    // R2/R3 fill transmit FIFO with engine stalled, then overflow
    for (int i = 0; i < 8; i++) tx_word(32'hA0B0C0D0 + 32'h0101_0101 * i);
    chk_evt("R2 tx count 32");
    tx_word(32'hDEAD_BEEF);
    chk_evt("R3 overflow flag");
    // R7/R8 write all ones clears sticky only
    wr(3'd1, 32'hFFFF_FFFF); m_ovf = 1'b0;
    chk_evt("R7 R8 live fields kept");
    // R10 mask readback and gating
    wr(3'd2, 32'hFFFF_FFFF); m_mask = 32'h0000_030F;
    rd(3'd2, d); check("R10 mask implemented bits", d, 32'h0000_030F);
    chk_irq("R10 irq low while nothing set");
    // drain
    @(posedge clk); #2 tx_ready = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 tx queue drained", txq.size(), 0);
    chk_irq("R10 irq from not-full");
    tx_word(32'h0102_0304);
    repeat (8) @(negedge clk);
    check("R2 concurrent drain", txq.size(), 0);
    wr(3'd2, 32'h0); m_mask = '0;

    // R4/R5/R6 receive paths
    foreach (d[i]) if (i < 5) rx_send(8'h11 * (i + 1));
    chk_evt("R4 rx count and flags");
    rx_word("R4 word oldest in MSB");
    rx_one("R5 byte read");
    rx_one("R6 empty byte read");
    chk_evt("R6 underflow set");
    wr(3'd1, 32'h0000_0008);
    chk_evt("R8 zero leaves underflow");
    wr(3'd1, 32'h0000_0004); m_udf = 1'b0;
    chk_evt("R8 underflow cleared");
    rx_send(8'h5A); rx_send(8'hA5);
    rx_word("R6 short word read");
    chk_evt("R6 nothing removed");
    rx_one("R5 first"); rx_one("R5 second");
    wr(3'd1, 32'hFFFF_FFFF); m_udf = 1'b0;

    // R9 thresholds
    wr(3'd0, 32'h0000_0002); m_rxthr = 2; m_txthr = 0;
    rd(3'd0, d); check("R9 cfg readback", d, 32'h0000_0002);
    rx_send(8'h77);
    chk_evt("R9 below rx threshold");
    rx_send(8'h88);
    chk_evt("R9 at rx threshold");
    wr(3'd2, 32'h0000_0002); m_mask = 32'h2;
    chk_irq("R9 R10 threshold irq");
    wr(3'd2, 32'h0); m_mask = '0;
    chk_irq("R10 masked off");
    rx_one("R5 drain a"); rx_one("R5 drain b");

    // R11 full receive FIFO
    for (int i = 0; i < DEPTH; i++) rx_send(8'(i * 7 + 1));
    rx_send(8'hEE);
    chk_evt("R11 full count");
    for (int i = 0; i < DEPTH / 4; i++) rx_word("R11 R4 full readout");
    chk_evt("R11 empty after readout");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule